// File: doc/BRIEF.md
# Page Write Staging Buffer and Programming Sequencer

This block sits between the serial bus front end of a small non-volatile memory and its 256x8 storage array. A write command first loads a start address. The upper nibble of that address picks a 16-byte row, and the lower nibble is a column pointer. The data bytes that follow are parked in a 16-slot staging buffer. Each strobe moves the column pointer forward within the row and wraps from column 15 back to column 0. A per-byte allow flag from the protection logic decides whether a byte is really staged. The column still advances when a byte is refused. Nothing reaches the array while bytes are being collected.

The STOP that closes the write starts a self-timed programming cycle, provided at least one byte was staged. During the cycle `busy` is held high for a fixed number of clocks, and the block ignores its inputs. In the first 16 clocks of the cycle, every staged slot is written through the array port in ascending column order. Slots that were never staged are skipped, so their array bytes keep their old contents. A START, or a fresh address load, that arrives before the STOP throws the staged bytes away. When the cycle ends, the address pointer rests on the location after the last byte sent, still inside the same row.

Top module: `pgw_sequencer`

## Requirements
- R1: While reset is applied and right after it is released, `busy` and `arr_we` are 0 and `cur_addr` is 0.
- R2: A pulse on `addr_load` while not busy sets `cur_addr` to `addr_in` in the next cycle.
- R3: Each byte strobe during a write adds one to `cur_addr[3:0]` modulo 16, and `cur_addr[7:4]` stays unchanged. For example, column 15 moves to column 0 of the same row.
- R4: A byte strobed with `byte_allow`=1 is staged at the current column. A later allowed byte at the same column, reached after a roll-over, replaces it.
- R5: A byte strobed with `byte_allow`=0 is never written to the array, but it still advances the column.
- R6: A `stop_evt` that follows at least one staged byte raises `busy` in the next cycle. `busy` then stays high for exactly PROG_CYCLES cycles.
- R7: During the programming cycle, each staged column c produces exactly one array write, in busy cycle c (counting from 0). The write address is {row, c} and the data is the last value staged at c. Unstaged columns produce no write, and no write happens while `busy` is 0.
- R8: A `stop_evt` with no staged byte produces no busy period and no array write.
- R9: A `start_evt` or `addr_load` before the STOP discards all staged bytes. After a `start_evt`, later byte strobes and STOPs are ignored until the next `addr_load`.
- R10: While `busy` is 1, `addr_load`, `byte_stb`, `start_evt` and `stop_evt` have no effect. `cur_addr`, the writes made and the busy length all stay as if those inputs had not been applied.
- R11: After the cycle, `cur_addr` is {row, (start column + number of strobes) mod 16}. Strobes and STOPs that arrive before the next `addr_load` change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_load | input | 1 | Start a write at `addr_in` |
| addr_in | input | ADDR_W | Start address: row in the upper bits, column in the low COL_W bits |
| byte_stb | input | 1 | One data byte has been received |
| byte_data | input | DATA_W | Byte that goes with `byte_stb` |
| byte_allow | input | 1 | Protection verdict for this byte (1 = may be written) |
| start_evt | input | 1 | Bus START seen; abandons an unfinished write |
| stop_evt | input | 1 | Bus STOP seen; closes the write |
| busy | output | 1 | Programming cycle in progress |
| cur_addr | output | ADDR_W | Current address pointer {row, column} |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |

## Verification
The assertions assume that the bus front end raises at most one of `addr_load`, `start_evt`, `stop_evt` and `byte_stb` in any one cycle, and that each of them is a single-cycle pulse. They also assume PROG_CYCLES is at least the row length, so the whole commit sweep fits inside the busy window. The bench drives each event from its own one-cycle task. It never overlaps two events, and it builds the DUT with a programming time longer than a row. The event injection used to test the busy-period rules still sends only one event per cycle.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  // Controller phases of a page write
  typedef enum logic [1:0] {
    PG_IDLE    = 2'd0,  // no write open
    PG_COLLECT = 2'd1,  // address loaded, bytes being staged
    PG_PROG    = 2'd2   // self-timed commit in progress
  } pg_state_e;

endpackage

// File: rtl/pgw_addr_counter.sv
module pgw_addr_counter #(
  parameter int ROW_W = 4,
  parameter int COL_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [ROW_W+COL_W-1:0] load_addr,
  input  logic                   step,
  output logic [ROW_W-1:0]       row_o,
  output logic [COL_W-1:0]       col_o
);

  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;

  always_comb begin
    row_d = row_q;
    col_d = col_q;
    if (load) begin
      row_d = load_addr[ROW_W+COL_W-1:COL_W];
      col_d = load_addr[COL_W-1:0];
    end else if (step) begin
      col_d = col_q + COL_W'(1);  // wraps inside the row
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (load || step) begin
      row_q <= row_d;
      col_q <= col_d;
    end
  end

  assign row_o = row_q;
  assign col_o = col_q;

  // R3: a step advances only the column, the row is frozen
  a_r3_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (row_q == $past(row_q)) && (col_q == $past(col_q) + COL_W'(1)));

  // R10: without load or step the pointer holds
  a_r10_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> ($stable(row_q) && $stable(col_q)));

endmodule

// File: rtl/pgw_stage_buf.sv
module pgw_stage_buf #(
  parameter int COL_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 wr_en,
  input  logic [COL_W-1:0]     wr_col,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [COL_W-1:0]     rd_col,
  output logic [(1<<COL_W)-1:0] valid_o,
  output logic [DATA_W-1:0]    rd_data
);

  localparam int SLOTS = 1 << COL_W;

  logic [DATA_W-1:0] slot_q [SLOTS];
  logic [SLOTS-1:0]  valid_q;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_col == COL_W'(s));

    // data holds no reset: its valid bit qualifies it
    always_ff @(posedge clk) begin
      if (hit) begin
        slot_q[s] <= wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[s] <= 1'b0;
      end else if (clear) begin
        valid_q[s] <= 1'b0;
      end else if (hit) begin
        valid_q[s] <= 1'b1;
      end
    end
  end

  assign valid_o = valid_q;
  assign rd_data = slot_q[rd_col];

  // R4: an accepted byte lands in its slot and marks it staged
  a_r4_slot_written: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clear) |=> (valid_q[$past(wr_col)] && (slot_q[$past(wr_col)] == $past(wr_data))));

  // R9: a clear empties the whole mask
  a_r9_mask_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (valid_q == '0));

endmodule

// File: rtl/pgw_prog_timer.sv
module pgw_prog_timer #(
  parameter int PROG_CYCLES = 64,
  parameter int CNT_W       = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last_tick;

  assign last_tick = busy_q && (cnt_q == LAST);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (busy_q) begin
      if (last_tick) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end else if (go) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q || go) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;
  assign done_o = last_tick;

  // R6: busy is never dropped before the full count
  a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (cnt_q != LAST)) |=> busy_q);

  // R6: busy falls only after the last count
  a_r6_busy_exact: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(cnt_q) == LAST));

  // R7: every cycle starts its sweep at column zero
  a_r7_sweep_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (cnt_q == '0));

endmodule

// File: rtl/pgw_sequencer.sv
module pgw_sequencer #(
  parameter int ADDR_W      = 8,
  parameter int COL_W       = 4,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 64   // must be at least 1<<COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              byte_allow,
  input  logic              start_evt,
  input  logic              stop_evt,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata
);

  import pgw_pkg::*;

  localparam int ROW_W  = ADDR_W - COL_W;
  localparam int SLOTS  = 1 << COL_W;
  localparam int CNT_W  = $clog2(PROG_CYCLES + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  pg_state_e        state_q, state_d;
  logic             cnt_load, cnt_step, buf_clear, stage_en, prog_go;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic [SLOTS-1:0] valid;
  logic [DATA_W-1:0] rd_data;
  logic             tmr_busy, tmr_done;
  logic [CNT_W-1:0] tmr_cnt;
  logic [COL_W-1:0] sweep_col;
  logic             sweep_on;

  // next-state process
  always_comb begin
    state_d   = state_q;
    cnt_load  = 1'b0;
    cnt_step  = 1'b0;
    buf_clear = 1'b0;
    stage_en  = 1'b0;
    prog_go   = 1'b0;
    case (state_q)
      PG_PROG: begin
        if (tmr_done) begin
          state_d   = PG_IDLE;
          buf_clear = 1'b1;
        end
      end
      default: begin
        if (addr_load) begin
          state_d   = PG_COLLECT;
          cnt_load  = 1'b1;
          buf_clear = 1'b1;
        end else if (start_evt) begin
          state_d   = PG_IDLE;
          buf_clear = 1'b1;
        end else if (state_q == PG_COLLECT) begin
          if (stop_evt) begin
            if (|valid) begin
              state_d = PG_PROG;
              prog_go = 1'b1;
            end else begin
              state_d = PG_IDLE;
            end
          end else if (byte_stb) begin
            cnt_step = 1'b1;
            stage_en = byte_allow;
          end
        end
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q <= PG_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  pgw_addr_counter #(
    .ROW_W (ROW_W),
    .COL_W (COL_W)
  ) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .load      (cnt_load),
    .load_addr (addr_in),
    .step      (cnt_step),
    .row_o     (row),
    .col_o     (col)
  );

  pgw_stage_buf #(
    .COL_W  (COL_W),
    .DATA_W (DATA_W)
  ) u_buf (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .clear   (buf_clear),
    .wr_en   (stage_en),
    .wr_col  (col),
    .wr_data (byte_data),
    .rd_col  (sweep_col),
    .valid_o (valid),
    .rd_data (rd_data)
  );

  pgw_prog_timer #(
    .PROG_CYCLES (PROG_CYCLES),
    .CNT_W       (CNT_W)
  ) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .go     (prog_go),
    .busy_o (tmr_busy),
    .cnt_o  (tmr_cnt),
    .done_o (tmr_done)
  );

  // commit sweep: first SLOTS cycles of the busy window, one column each
  assign sweep_col = tmr_cnt[COL_W-1:0];
  assign sweep_on  = tmr_busy && (tmr_cnt < CNT_W'(SLOTS));

  assign busy      = tmr_busy;
  assign cur_addr  = {row, col};
  assign arr_we    = sweep_on && valid[sweep_col];
  assign arr_addr  = {row, sweep_col};
  assign arr_wdata = rd_data;

  // R6: the controller phase and the timer agree
  a_r6_phase_match: assert property (@(posedge clk) disable iff (!rst_n_int)
    busy == (state_q == PG_PROG));

  // R6: a committing STOP starts the timer on the next edge
  a_r6_stop_starts: assert property (@(posedge clk) disable iff (!rst_n_int)
    prog_go |=> busy);

  // R8: a STOP with an empty buffer never opens a busy window
  a_r8_empty_stop: assert property (@(posedge clk) disable iff (!rst_n_int)
    ((state_q == PG_COLLECT) && stop_evt && !addr_load && !start_evt && (valid == '0)) |=> !busy);

  // R7: the array is written only inside the busy window
  a_r7_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n_int)
    arr_we |-> busy);

  // R10: nothing is staged or stepped while busy
  a_r10_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n_int)
    busy |-> (!stage_en && !cnt_step && !cnt_load));

endmodule

// File: tb/pgw_sequencer_tb.sv
`timescale 1ns/100ps
module pgw_sequencer_tb;

  localparam int PROG = 24;

  logic       clk;
  logic       rst_n;
  logic       addr_load;
  logic [7:0] addr_in;
  logic       byte_stb;
  logic [7:0] byte_data;
  logic       byte_allow;
  logic       start_evt;
  logic       stop_evt;
  logic       busy;
  logic [7:0] cur_addr;
  logic       arr_we;
  logic [7:0] arr_addr;
  logic [7:0] arr_wdata;

  pgw_sequencer #(
    .ADDR_W (8), .COL_W (4), .DATA_W (8), .PROG_CYCLES (PROG)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .addr_load (addr_load), .addr_in (addr_in),
    .byte_stb (byte_stb), .byte_data (byte_data), .byte_allow (byte_allow),
    .start_evt (start_evt), .stop_evt (stop_evt), .busy (busy),
    .cur_addr (cur_addr), .arr_we (arr_we), .arr_addr (arr_addr),
    .arr_wdata (arr_wdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;

  // write log gathered away from the active edge
  int       nlog;
  int       bcnt;
  int       stray;
  logic [7:0] log_addr [32];
  logic [7:0] log_data [32];
  int         log_when [32];

  always @(negedge clk) begin
    if (busy) begin
      if (arr_we && nlog < 32) begin
        log_addr[nlog] = arr_addr;
        log_data[nlog] = arr_wdata;
        log_when[nlog] = bcnt;
      end
      if (arr_we) nlog = nlog + 1;
      bcnt = bcnt + 1;
    end else if (arr_we) begin
      stray = stray + 1;
    end
  end

  // bench model of the expected write
  logic [3:0] exp_row;
  logic [3:0] exp_col;
  logic       exp_valid [16];
  logic [7:0] exp_buf [16];

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_log();
    nlog = 0; bcnt = 0; stray = 0;
  endtask

  task automatic model_load(input logic [7:0] a);
    exp_row = a[7:4];
    exp_col = a[3:0];
    for (int c = 0; c < 16; c++) exp_valid[c] = 1'b0;
  endtask

  task automatic drv_load(input logic [7:0] a);
    addr_load = 1'b1; addr_in = a;
    tick();
    addr_load = 1'b0;
  endtask

  task automatic drv_byte(input logic [7:0] d, input logic al);
    byte_stb = 1'b1; byte_data = d; byte_allow = al;
    tick();
    byte_stb = 1'b0;
  endtask

  task automatic drv_stop();
    stop_evt = 1'b1;
    tick();
    stop_evt = 1'b0;
  endtask

  task automatic drv_start();
    start_evt = 1'b1;
    tick();
    start_evt = 1'b0;
  endtask

  task automatic model_byte(input logic [7:0] d, input logic al);
    if (al) begin
      exp_buf[exp_col]   = d;
      exp_valid[exp_col] = 1'b1;
    end
    exp_col = exp_col + 4'd1;
  endtask

  // wait out a possible commit, then compare against the model
  task automatic expect_commit(input string tag);
    int nexp;
    int k;
    nexp = 0;
    for (int c = 0; c < 16; c++) if (exp_valid[c]) nexp++;
    for (int w = 0; w < PROG + 4; w++) tick();
    if (nexp > 0) chk("R6", bcnt, PROG, {tag, " busy length"});
    else          chk("R8", bcnt, 0,    {tag, " busy length with empty buffer"});
    chk("R7", nlog, nexp, {tag, " write count"});
    chk("R7", stray, 0, {tag, " writes outside busy"});
    k = 0;
    for (int c = 0; c < 16; c++) begin
      if (exp_valid[c]) begin
        if (k < nlog && k < 32) begin
          chk("R7", log_addr[k], {exp_row, 4'(c)}, {tag, " write address"});
          chk("R4", log_data[k], exp_buf[c], {tag, " write data"});
          chk("R7", log_when[k], c, {tag, " write slot timing"});
        end
        k++;
      end
    end
    chk("R11", cur_addr, {exp_row, exp_col}, {tag, " pointer after cycle"});
  endtask

  logic wd_hit = 1'b0;
  logic done = 1'b0;

  initial begin
    #(200000 * 5);
    if (!done) begin
      wd_hit = 1'b1;
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr_load = 1'b0; addr_in = '0; byte_stb = 1'b0;
    byte_data = '0; byte_allow = 1'b0; start_evt = 1'b0; stop_evt = 1'b0;
    clear_log();
    for (int c = 0; c < 16; c++) begin exp_valid[c] = 1'b0; exp_buf[c] = '0; end
    exp_row = '0; exp_col = '0;
    tick(); tick();
    // R1: quiet while reset is held
    chk("R1", busy, 0, "busy in reset");
    chk("R1", arr_we, 0, "arr_we in reset");
    chk("R1", cur_addr, 0, "cur_addr in reset");
    rst_n = 1'b1;
    tick(); tick(); tick();
    chk("R1", busy, 0, "busy after reset");
    chk("R1", cur_addr, 0, "cur_addr after reset");

    // R2: address load visible on the pointer
    drv_load(8'hA7);
    chk("R2", cur_addr, 8'hA7, "pointer after load");
    drv_start();

    // sweep start column x length, with roll-over and refused bytes
    for (int st = 0; st < 16; st++) begin
      for (int len = 1; len <= 20; len++) begin
        logic [7:0] a;
        int seed;
        seed = st * 20 + len;
        a = {4'((st * 5 + 3) % 16), 4'(st)};
        clear_log();
        model_load(a);
        drv_load(a);
        chk("R2", cur_addr, a, "pointer after load");
        for (int i = 0; i < len; i++) begin
          logic [7:0] d;
          logic al;
          d  = 8'((seed * 29 + i * 17 + 3) & 255);
          al = ((i + seed) % 5) != 4;   // R5: some bytes refused
          drv_byte(d, al);
          model_byte(d, al);
          chk("R3", cur_addr, {exp_row, exp_col}, "pointer after strobe");
        end
        drv_stop();
        expect_commit("sweep");
      end
    end

    // R8: every byte refused, STOP starts nothing
    clear_log();
    model_load(8'h40);
    drv_load(8'h40);
    drv_byte(8'h11, 1'b0); model_byte(8'h11, 1'b0);
    drv_byte(8'h22, 1'b0); model_byte(8'h22, 1'b0);
    drv_stop();
    expect_commit("R8 refused");

    // R9: START before STOP discards the buffer
    clear_log();
    model_load(8'h93);
    drv_load(8'h93);
    drv_byte(8'h5A, 1'b1); model_byte(8'h5A, 1'b1);
    drv_byte(8'h6B, 1'b1); model_byte(8'h6B, 1'b1);
    drv_start();
    for (int c = 0; c < 16; c++) exp_valid[c] = 1'b0;
    drv_byte(8'h7C, 1'b1);   // R9: no write open, ignored
    chk("R9", cur_addr, {exp_row, exp_col}, "strobe after START");
    drv_stop();
    expect_commit("R9 start discard");

    // R9: a new load before STOP discards the old bytes
    clear_log();
    model_load(8'h20);
    drv_load(8'h20);
    drv_byte(8'hC3, 1'b1);
    model_load(8'h38);
    drv_load(8'h38);
    drv_stop();
    expect_commit("R9 reload discard");

    // R10: events injected inside the busy window are ignored
    clear_log();
    model_load(8'h5C);
    drv_load(8'h5C);
    drv_byte(8'hE1, 1'b1); model_byte(8'hE1, 1'b1);
    drv_byte(8'hE2, 1'b1); model_byte(8'hE2, 1'b1);
    drv_byte(8'hE3, 1'b1); model_byte(8'hE3, 1'b1);
    drv_stop();
    tick();
    drv_load(8'h11);
    chk("R10", cur_addr, 8'h5F, "pointer after load while busy");
    drv_byte(8'h99, 1'b1);
    drv_start();
    drv_stop();
    chk("R10", cur_addr, 8'h5F, "pointer after events while busy");
    expect_commit("R10 busy inject");

    // R11: strobes and STOP after the cycle without a new load
    clear_log();
    for (int c = 0; c < 16; c++) exp_valid[c] = 1'b0;
    drv_byte(8'h44, 1'b1);
    drv_stop();
    expect_commit("R11 after cycle");

    done = 1'b1;
    if (!wd_hit) begin
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule